// File: doc/BRIEF.md
# Ping-Pong DMA Address Selector

This block sits beside a DMA stream and keeps the three addresses that the stream works with: one peripheral address and two memory buffer addresses. It uses the programmed transfer direction to decide which address feeds the source output and which feeds the destination output. When double-buffer operation is on, the current-target bit picks which memory buffer is live. The block counts transferred items. At the end of each buffer it flips the current target and reloads the count, so software can refill one buffer while the stream drains or fills the other.

The block also guards its configuration. Double-buffer operation forces circular behaviour on. A memory-to-memory direction with double-buffer on, and the reserved direction code, are both flagged as configuration errors, and the stream refuses to start with either. While the stream runs, every register write is locked out except a write to the memory buffer that is not currently live in double-buffer mode. Each rejected write raises an error pulse.

Top module: `dbuf_addr_sel`

## Requirements
- R1: After reset, busy, cur_tgt, remaining, circ_on, wr_err and cfg_err are 0, and src_addr and dst_addr are 0.
- R2: Direction code 00 routes the peripheral address to src_addr and the live memory buffer to dst_addr. Code 01 routes the live buffer to src_addr and the peripheral address to dst_addr.
- R3: The live memory buffer is buffer 1 when double-buffer is on and cur_tgt is 1. In every other case it is buffer 0, so cur_tgt has no effect without double-buffer.
- R4: In double-buffer mode, cur_tgt inverts on the clock edge where a beat arrives while busy and remaining equals 1.
- R5: Setting the double-buffer bit forces circ_on to 1 even when the circular bit is 0.
- R6: Direction 10 (memory-to-memory) routes the peripheral address to src_addr and buffer 0 to dst_addr, and a stream may start with it. Direction 10 with double-buffer on sets cfg_err, and a rising stream_en does not start the stream.
- R7: Direction 11 sets cfg_err, drives both address outputs to 0, and keeps the stream from starting.
- R8: Without double-buffer, writes to either memory buffer register while busy are ignored, and wr_err pulses for one cycle.
- R9: With double-buffer on and busy, a write to the buffer that is not live is accepted. A write to the live buffer is ignored and pulses wr_err.
- R10: A beat at remaining equal to 1 reloads remaining with the programmed count on the same edge when circ_on is 1. When circ_on is 0, it clears remaining and busy instead. Any other beat while busy decrements remaining. A rising stream_en with a legal configuration and a nonzero count sets busy and loads remaining.
- R11: The register select is decoded as follows: 0 is control, 1 is the peripheral address, 2 is buffer 0, 3 is buffer 1 and 4 is the count. Control holds the direction in bits 1:0, circular in bit 2, double-buffer in bit 3 and cur_tgt in bit 4. While busy, writes to control, the peripheral address and the count are ignored and pulse wr_err. Dropping stream_en clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | AW | Write data |
| stream_en | input | 1 | Stream enable; a rising edge starts the stream |
| beat | input | 1 | One item transferred |
| src_addr | output | AW | Selected source address |
| dst_addr | output | AW | Selected destination address |
| cur_tgt | output | 1 | Current memory target |
| circ_on | output | 1 | Effective circular mode |
| busy | output | 1 | Stream running |
| cfg_err | output | 1 | Illegal configuration |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| remaining | output | CW | Items left in the current buffer |

## Verification
The hardest situation to reach is a buffer rewrite that races the target flip. Software has to write the newly idle buffer right after cur_tgt inverts and then find the old live buffer locked. The bench reaches it by running a short double-buffer stream and stepping beats one at a time. Around each flip it tries writes to both buffers and reads the accepted value back through the routed destination address once the target returns to it.

// File: rtl/dbuf_addr_sel.sv
module dbuf_addr_sel #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          stream_en,
  input  logic          beat,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          cur_tgt,
  output logic          circ_on,
  output logic          busy,
  output logic          cfg_err,
  output logic          wr_err,
  output logic [CW-1:0] remaining
);
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_PAR  = 3'd1;
  localparam logic [2:0] SEL_M0   = 3'd2;
  localparam logic [2:0] SEL_M1   = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  logic [1:0]    dir;
  logic          circ, dbm, en_q;
  logic [AW-1:0] par, m0, m1, mem_act;
  logic [CW-1:0] ndt;
  logic          last, m0_ok, m1_ok, start;

  assign cfg_err = (dir == 2'b11) || (dir == 2'b10 && dbm);
  assign circ_on = circ | dbm;
  assign mem_act = (dbm && cur_tgt) ? m1 : m0;
  assign last    = busy && stream_en && beat && (remaining == CW'(1));
  assign m0_ok   = !busy || (dbm && cur_tgt);
  assign m1_ok   = !busy || (dbm && !cur_tgt);
  assign start   = !busy && stream_en && !en_q && !cfg_err && (ndt != '0);

  always_comb begin
    case (dir)
      2'b00:   begin src_addr = par;     dst_addr = mem_act; end
      2'b01:   begin src_addr = mem_act; dst_addr = par;     end
      2'b10:   begin src_addr = par;     dst_addr = m0;      end
      default: begin src_addr = '0;      dst_addr = '0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0; circ <= 1'b0; dbm <= 1'b0; cur_tgt <= 1'b0;
      par <= '0; m0 <= '0; m1 <= '0; ndt <= '0;
      remaining <= '0; busy <= 1'b0; en_q <= 1'b0; wr_err <= 1'b0;
    end else begin
      en_q   <= stream_en;
      wr_err <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: if (!busy) begin
                      dir <= wr_data[1:0]; circ <= wr_data[2];
                      dbm <= wr_data[3];   cur_tgt <= wr_data[4];
                    end else wr_err <= 1'b1;
          SEL_PAR:  if (!busy) par <= wr_data; else wr_err <= 1'b1;
          SEL_M0:   if (m0_ok) m0 <= wr_data; else wr_err <= 1'b1;
          SEL_M1:   if (m1_ok) m1 <= wr_data; else wr_err <= 1'b1;
          SEL_CNT:  if (!busy) ndt <= wr_data[CW-1:0]; else wr_err <= 1'b1;
          default:  ;
        endcase
      end
      if (busy) begin
        if (!stream_en) busy <= 1'b0;
        else if (last) begin
          if (circ_on) begin
            remaining <= ndt;
            if (dbm) cur_tgt <= ~cur_tgt;
          end else begin
            remaining <= '0;
            busy      <= 1'b0;
          end
        end else if (beat) remaining <= remaining - CW'(1);
      end else if (start) begin
        busy      <= 1'b1;
        remaining <= ndt;
      end
    end
  end

  a_r4_ct_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (last && dbm) |=> (cur_tgt != $past(cur_tgt)));
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (last && circ_on) |=> (busy && remaining == ndt));
  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !circ_on) |=> (!busy && remaining == '0));
  a_r8_mem_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dbm && wr_en && (wr_sel == SEL_M0 || wr_sel == SEL_M1))
      |=> ($stable(m0) && $stable(m1) && wr_err));
  a_r9_live_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbm && wr_en && wr_sel == (cur_tgt ? SEL_M1 : SEL_M0)) |=> wr_err);
  a_r7_no_bad_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cfg_err);
endmodule

// File: tb/dbuf_addr_sel_bench.sv
module dbuf_addr_sel_bench;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam logic [AW-1:0] PA = 32'h1000, MA0 = 32'h2000, MA1 = 32'h3000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, stream_en = 1'b0, beat = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] src_addr, dst_addr;
  logic cur_tgt, circ_on, busy, cfg_err, wr_err;
  logic [CW-1:0] remaining;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbuf_addr_sel #(.AW(AW), .CW(CW)) u_dbuf_addr_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stream_en(stream_en), .beat(beat), .src_addr(src_addr), .dst_addr(dst_addr),
    .cur_tgt(cur_tgt), .circ_on(circ_on), .busy(busy), .cfg_err(cfg_err),
    .wr_err(wr_err), .remaining(remaining));

  // {dir[8:7], dbm[6], ct[5], src code[4:3], dst code[2:1], cfg_err[0]}
  // code 0 = peripheral, 1 = buffer 0, 2 = buffer 1, 3 = zero
  localparam logic [8:0] VEC [10] = '{
    {2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
    {2'b00, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0},
    {2'b00, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0},
    {2'b00, 1'b1, 1'b1, 2'd0, 2'd2, 1'b0},
    {2'b01, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0},
    {2'b01, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0},
    {2'b01, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0},
    {2'b10, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
    {2'b10, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1},
    {2'b11, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1}
  };

  function automatic logic [AW-1:0] code_addr(input logic [1:0] c);
    case (c)
      2'd0: return PA;
      2'd1: return MA0;
      2'd2: return MA1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] ctl(input logic [1:0] d, input logic c,
                                        input logic db, input logic t);
    return {27'b0, t, db, c, d};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [AW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic en(input logic v);
    @(negedge clk); stream_en = v;
    @(negedge clk);
  endtask

  task automatic pulse;
    @(negedge clk); beat = 1'b1;
    @(negedge clk); beat = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 cur_tgt", cur_tgt, 0);
    chk("R1 remaining", remaining, 0); chk("R1 circ_on", circ_on, 0);
    chk("R1 wr_err", wr_err, 0); chk("R1 src", src_addr, 0);
    chk("R1 dst", dst_addr, 0); chk("R1 cfg_err", cfg_err, 0);
    rst_n = 1'b1;

    wr(3'd1, PA); wr(3'd2, MA0); wr(3'd3, MA1);
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, ctl(VEC[i][8:7], 1'b0, VEC[i][6], VEC[i][5]));
      chk($sformatf("R2 R3 R6 R7 R11 vec%0d src", i), src_addr, code_addr(VEC[i][4:3]));
      chk($sformatf("R2 R3 R6 R7 R11 vec%0d dst", i), dst_addr, code_addr(VEC[i][2:1]));
      chk($sformatf("R6 R7 vec%0d cfg_err", i), cfg_err, VEC[i][0]);
    end

    // double-buffer ping-pong, count 3
    wr(3'd4, 3); wr(3'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    chk("R5 circ forced", circ_on, 1);
    en(1'b1);
    chk("R10 start busy", busy, 1); chk("R10 start count", remaining, 3);
    wr(3'd2, 32'h2222);
    chk("R9 live write err", wr_err, 1); chk("R9 live unchanged", dst_addr, MA0);
    wr(3'd3, 32'h3333);
    chk("R9 idle write ok", wr_err, 0);
    pulse; pulse;
    chk("R10 decrement", remaining, 1); chk("R4 no early flip", cur_tgt, 0);
    pulse;
    chk("R4 flip", cur_tgt, 1); chk("R10 reload", remaining, 3);
    chk("R9 new buffer routed", dst_addr, 32'h3333);
    wr(3'd2, 32'h2444); chk("R9 idle buf0 ok", wr_err, 0);
    wr(3'd3, 32'h3999); chk("R9 live buf1 err", wr_err, 1);
    pulse; pulse; pulse;
    chk("R4 flip back", cur_tgt, 0); chk("R9 buf0 rewrite routed", dst_addr, 32'h2444);
    wr(3'd0, ctl(2'b01, 1'b0, 1'b0, 1'b0));
    chk("R11 ctrl locked err", wr_err, 1); chk("R11 ctrl locked", src_addr, PA);
    wr(3'd4, 9); chk("R11 count locked err", wr_err, 1);
    en(1'b0); chk("R11 disable", busy, 0);

    // single-shot, no double-buffer
    wr(3'd4, 2); wr(3'd0, ctl(2'b01, 1'b0, 1'b0, 1'b1));
    chk("R5 circ off", circ_on, 0); chk("R3 ct ignored", src_addr, 32'h2444);
    en(1'b1); chk("R10 start", busy, 1);
    wr(3'd2, 32'h5555); chk("R8 locked err", wr_err, 1);
    chk("R8 buf0 unchanged", src_addr, 32'h2444);
    wr(3'd3, 32'h5555); chk("R8 buf1 locked err", wr_err, 1);
    pulse; pulse;
    chk("R10 stop busy", busy, 0); chk("R10 stop count", remaining, 0);
    chk("R4 no flip without dbm", cur_tgt, 1);
    en(1'b0);

    // circular without double-buffer
    wr(3'd0, ctl(2'b00, 1'b1, 1'b0, 1'b0));
    en(1'b1); pulse; pulse;
    chk("R10 circ stays busy", busy, 1); chk("R10 circ reload", remaining, 2);
    chk("R4 circ no flip", cur_tgt, 0);
    en(1'b0);

    // illegal configurations
    wr(3'd0, ctl(2'b11, 1'b0, 1'b0, 1'b0)); en(1'b1);
    chk("R7 reserved no start", busy, 0); en(1'b0);
    wr(3'd0, ctl(2'b10, 1'b0, 1'b1, 1'b0)); en(1'b1);
    chk("R6 m2m dbm no start", busy, 0); en(1'b0);
    wr(3'd0, ctl(2'b10, 1'b0, 1'b0, 1'b0)); en(1'b1);
    chk("R6 m2m start", busy, 1); en(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule